// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit performs the shift and rotate operations of a 32-bit RISC core and also produces the zero, negative and carry flags. The core's issue logic supplies an operation code, the source operand and a 5-bit immediate taken from the instruction word. The full count register is also supplied: rotate-by-register reads its low bits, and the signed-count shift reads all of it. The unit registers the result and the flags one clock later, and the writeback path picks them up there.

The immediate forms treat a zero field as a count of 32. The signed-count shift changes direction with the sign of its count. A negative count shifts left and a non-negative count shifts right arithmetically. Counts whose magnitude reaches the word width saturate: a left shift gives all zeros and a right shift gives the sign fill. Every operation takes its carry from a fixed end of the original operand.

Top module: `shrot_unit`

## Requirements
- R1: Operation code 0 (immediate left shift) shifts the operand left by 32 minus the immediate, so an immediate of 0 gives a shift of 32 and a zero result. Carry is operand bit 31.
- R2: Operation code 1 (immediate logical right shift) shifts right with zero fill by the immediate, where 0 means 32 and gives a zero result with no wrap to a shift of 0. Carry is operand bit 0.
- R3: Operation code 2 (immediate arithmetic right shift) shifts right with sign fill by the immediate, where 0 means 32 and fills every bit with operand bit 31. Carry is operand bit 0.
- R4: Operation code 3 (immediate rotate right) rotates right by the immediate, where 0 means 32 and so returns the operand unchanged. Carry is operand bit 31.
- R5: Operation code 4 (register rotate right) rotates right by bits 4:0 of the count input, and the upper count bits have no effect. Carry is operand bit 31.
- R6: Operation code 5 (signed-count shift) with a negative count shifts left by the count's magnitude. A count of -32 or less gives zero. Carry is operand bit 31.
- R7: Operation code 5 with a count of zero or more shifts right arithmetically by the count. A count of 32 or more fills the result with operand bit 31. Carry is operand bit 0.
- R8: For every operation, flag Z is 1 exactly when the result is zero, and flag N equals result bit 31.
- R9: Operation codes 6 and 7 are reserved. They pass the operand through unchanged, with carry 0.
- R10: A request accepted with in_valid high at a clock edge appears on the outputs after that edge, with out_valid high for one cycle. While in_valid is low, out_valid is low and the result and flags hold.
- R11: While rst_n is low, out_valid, the result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0..7, see requirements) |
| operand | input | 32 | Value to shift or rotate |
| count | input | 32 | Count register value (rotate and signed-count shift) |
| imm | input | 5 | Immediate count field |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 32 | Shifted or rotated value |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |

## Verification
Each operation code is swept over all 32 immediate values, which separates the zero-means-32 encodings from a plain modulo count. The signed-count shift is driven with the counts 0, ±1, ±31, ±32, ±33 and the extreme 32-bit values, which probe the direction change and both saturation edges. Random operands with bit 31 and bit 0 set independently show whether the carry comes from the correct end and whether the fill is signed. Counts with random upper bits check that rotate-by-register ignores them, and idle cycles with changing inputs check that the outputs hold.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [2:0] {
    OP_SHL_IMM = 3'd0,
    OP_SHR_IMM = 3'd1,
    OP_SAR_IMM = 3'd2,
    OP_ROR_IMM = 3'd3,
    OP_ROR_REG = 3'd4,
    OP_SHA_REG = 3'd5,
    OP_RSV_6   = 3'd6,
    OP_RSV_7   = 3'd7
  } shr_op_e;

  // What enters the vacated bit positions during a right-going shift
  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_WRAP = 2'd2
  } shr_fill_e;

  // Which end of the original operand feeds the carry flag
  typedef enum logic [1:0] {
    CSEL_NONE = 2'd0,
    CSEL_LSB  = 2'd1,
    CSEL_MSB  = 2'd2
  } shr_csel_e;

  typedef struct packed {
    logic      reverse;  // left shift done as mirrored right shift
    shr_fill_e fill;
    shr_csel_e csel;
  } shr_plan_t;

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH),
  parameter int AMT_W = IMM_W + 1
) (
  input  shr_op_e          op,
  input  logic [IMM_W-1:0] imm,
  input  logic [WIDTH-1:0] count,
  output shr_plan_t        plan,
  output logic [AMT_W-1:0] amt
);

  localparam logic [AMT_W-1:0] FULL = AMT_W'(WIDTH);

  // Immediate field where zero stands for a full-width count
  function automatic logic [AMT_W-1:0] imm_count(input logic [IMM_W-1:0] f);
    return (f == '0) ? FULL : {1'b0, f};
  endfunction

  // Magnitude of a signed count, clamped to the word width
  function automatic logic [AMT_W-1:0] clamp_mag(input logic [WIDTH-1:0] c);
    logic [WIDTH:0] mag;
    mag = c[WIDTH-1] ? ({1'b0, ~c} + 1'b1) : {1'b0, c};
    return (mag >= (WIDTH+1)'(WIDTH)) ? FULL : mag[AMT_W-1:0];
  endfunction

  logic count_neg;
  assign count_neg = count[WIDTH-1];

  always_comb begin
    plan = '{reverse: 1'b0, fill: FILL_ZERO, csel: CSEL_NONE};
    amt  = '0;
    unique case (op)
      OP_SHL_IMM: begin
        plan.reverse = 1'b1;
        plan.csel    = CSEL_MSB;
        amt          = FULL - {1'b0, imm};
      end
      OP_SHR_IMM: begin
        plan.csel = CSEL_LSB;
        amt       = imm_count(imm);
      end
      OP_SAR_IMM: begin
        plan.fill = FILL_SIGN;
        plan.csel = CSEL_LSB;
        amt       = imm_count(imm);
      end
      OP_ROR_IMM: begin
        plan.fill = FILL_WRAP;
        plan.csel = CSEL_MSB;
        amt       = {1'b0, imm};
      end
      OP_ROR_REG: begin
        plan.fill = FILL_WRAP;
        plan.csel = CSEL_MSB;
        amt       = {1'b0, count[IMM_W-1:0]};
      end
      OP_SHA_REG: begin
        amt = clamp_mag(count);
        if (count_neg) begin
          plan.reverse = 1'b1;
          plan.csel    = CSEL_MSB;
        end else begin
          plan.fill = FILL_SIGN;
          plan.csel = CSEL_LSB;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int AMT_W = $clog2(WIDTH) + 1
) (
  input  logic [WIDTH-1:0] data,
  input  logic [AMT_W-1:0] amt,
  input  shr_fill_e        fill,
  input  logic             reverse,
  output logic [WIDTH-1:0] data_out
);

  function automatic logic [WIDTH-1:0] mirror(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int b = 0; b < WIDTH; b++) r[b] = v[WIDTH-1-b];
    return r;
  endfunction

  logic             sign_bit;
  logic [WIDTH-1:0] stage [AMT_W+1];

  assign sign_bit = data[WIDTH-1];
  assign stage[0] = reverse ? mirror(data) : data;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int SH = 1 << i;
    if (SH >= WIDTH) begin : g_full
      logic [WIDTH-1:0] full_fill;
      assign full_fill = (fill == FILL_SIGN) ? {WIDTH{sign_bit}} :
                         (fill == FILL_WRAP) ? stage[i] : '0;
      assign stage[i+1] = amt[i] ? full_fill : stage[i];
    end else begin : g_part
      logic [SH-1:0] top_bits;
      assign top_bits = (fill == FILL_SIGN) ? {SH{sign_bit}} :
                        (fill == FILL_WRAP) ? stage[i][SH-1:0] : '0;
      assign stage[i+1] = amt[i] ? {top_bits, stage[i][WIDTH-1:SH]} : stage[i];
    end
  end

  assign data_out = reverse ? mirror(stage[AMT_W]) : stage[AMT_W];

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic [WIDTH-1:0] orig,
  input  shr_csel_e        csel,
  output logic             z,
  output logic             n,
  output logic             c
);

  assign z = (res == '0);
  assign n = res[WIDTH-1];

  always_comb begin
    unique case (csel)
      CSEL_LSB: c = orig[0];
      CSEL_MSB: c = orig[WIDTH-1];
      default:  c = 1'b0;
    endcase
  end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op_sel,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] count,
  input  logic [IMM_W-1:0] imm,
  output logic             out_valid,
  output logic [WIDTH-1:0] result,
  output logic             flag_z,
  output logic             flag_n,
  output logic             flag_c
);

  localparam int AMT_W = IMM_W + 1;

  shr_plan_t        plan;
  logic [AMT_W-1:0] shift_amt;
  logic [WIDTH-1:0] res_next;
  logic             z_next, n_next, c_next;

  shrot_decode #(.WIDTH(WIDTH), .IMM_W(IMM_W), .AMT_W(AMT_W)) u_decode (
    .op    (shr_op_e'(op_sel)),
    .imm   (imm),
    .count (count),
    .plan  (plan),
    .amt   (shift_amt)
  );

  shrot_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
    .data     (operand),
    .amt      (shift_amt),
    .fill     (plan.fill),
    .reverse  (plan.reverse),
    .data_out (res_next)
  );

  shrot_flags #(.WIDTH(WIDTH)) u_flags (
    .res  (res_next),
    .orig (operand),
    .csel (plan.csel),
    .z    (z_next),
    .n    (n_next),
    .c    (c_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_z    <= 1'b0;
      flag_n    <= 1'b0;
      flag_c    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_next;
        flag_z <= z_next;
        flag_n <= n_next;
        flag_c <= c_next;
      end
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [2:0]       op_sel,
  input logic [WIDTH-1:0] operand,
  input logic [WIDTH-1:0] count,
  input logic [IMM_W-1:0] imm,
  input logic             out_valid,
  input logic [WIDTH-1:0] result,
  input logic             flag_z,
  input logic             flag_n,
  input logic             flag_c
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_zero_R11: assert (!out_valid && result == '0 && !flag_z && !flag_n && !flag_c);
    end
  end

  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_z) && $stable(flag_c)));

  assert_shl_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd0) |=> flag_c == $past(operand[WIDTH-1]));

  assert_shr_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd1 && imm == '0) |=> (result == '0 && flag_z && flag_c == $past(operand[0])));

  assert_ror_whole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd4 && count[IMM_W-1:0] == '0) |=> result == $past(operand));

  assert_sha_left_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5 && $signed(count) <= -WIDTH) |=> (result == '0 && flag_z));

  assert_sha_right_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5 && $signed(count) >= WIDTH) |=> result == {WIDTH{$past(operand[WIDTH-1])}});

  assert_reserved_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel[2:1] == 2'b11) |=> (result == $past(operand) && !flag_c));

endmodule

bind shrot_unit shrot_unit_chk #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .operand(operand), .count(count), .imm(imm), .out_valid(out_valid),
  .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
);

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] operand = '0;
  logic [31:0] count = '0;
  logic [4:0]  imm = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_z, flag_n, flag_c;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  shrot_unit u_shrot_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .operand(operand), .count(count), .imm(imm), .out_valid(out_valid),
    .result(result), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  function automatic logic [31:0] rot_right(input logic [31:0] a, input int n);
    logic [63:0] t;
    t = {a, a} >> (n % 32);
    return t[31:0];
  endfunction

  function automatic logic [31:0] sar(input logic [31:0] a, input longint n);
    if (n >= 32) return {32{a[31]}};
    return 32'($signed(a) >>> n);
  endfunction

  // Returns {c, result}
  function automatic logic [32:0] model(input logic [2:0] op, input logic [31:0] a,
                                        input logic [31:0] cnt, input logic [4:0] im);
    int     n;
    longint sc;
    n = (im == 0) ? 32 : int'(im);
    case (op)
      3'd0: begin n = 32 - int'(im); return {a[31], (n >= 32) ? 32'h0 : (a << n)}; end
      3'd1: return {a[0], (n >= 32) ? 32'h0 : (a >> n)};
      3'd2: return {a[0], sar(a, n)};
      3'd3: return {a[31], rot_right(a, int'(im))};
      3'd4: return {a[31], rot_right(a, int'(cnt[4:0]))};
      3'd5: begin
        sc = longint'($signed(cnt));
        if (sc < 0) return {a[31], (-sc >= 32) ? 32'h0 : (a << (-sc))};
        return {a[0], sar(a, sc)};
      end
      default: return {1'b0, a};
    endcase
  endfunction

  function automatic string tag(input logic [2:0] op, input logic [31:0] cnt);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      3'd5: return cnt[31] ? "R6" : "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [31:0] a,
                        input logic [31:0] cnt, input logic [4:0] im);
    logic [32:0] exp;
    logic        ez, en;
    @(negedge clk);
    op_sel = op; operand = a; count = cnt; imm = im; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(op, a, cnt, im);
    ez = (exp[31:0] == 32'h0);
    en = exp[31];
    checks++;
    if (!out_valid || result !== exp[31:0] || flag_c !== exp[32] ||
        flag_z !== ez || flag_n !== en) begin
      errors++;
      $display("FAIL %s R8 R10 op=%0d a=%h cnt=%h imm=%0d: got v=%b r=%h z=%b n=%b c=%b exp v=1 r=%h z=%b n=%b c=%b",
               tag(op, cnt), op, a, cnt, im, out_valid, result, flag_z, flag_n, flag_c,
               exp[31:0], ez, en, exp[32]);
    end
  endtask

  initial begin
    logic [31:0] sha_counts [12];
    logic [31:0] keep_r;
    logic        keep_z, keep_n, keep_c;
    void'($urandom(32'd20240611));
    sha_counts = '{32'd0, 32'd1, 32'd31, 32'd32, 32'd33, 32'hFFFF_FFFF,
                   32'hFFFF_FFE1, 32'hFFFF_FFE0, 32'hFFFF_FFDF, 32'h8000_0000,
                   32'h7FFF_FFFF, 32'hFFFF_FFFE};

    // R11: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0 || flag_z !== 1'b0 || flag_n !== 1'b0 || flag_c !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset: got v=%b r=%h z=%b n=%b c=%b exp all zero",
               out_valid, result, flag_z, flag_n, flag_c);
    end
    rst_n = 1'b1;

    // Directed sweep of every immediate for the immediate forms (R1..R4)
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 32; k++) begin
        run_op(3'(op), 32'h8000_0001, 32'h0, 5'(k));
        run_op(3'(op), 32'h7654_3210, 32'h0, 5'(k));
      end
    end

    // R5: upper count bits ignored, all low counts
    for (int k = 0; k < 32; k++) run_op(3'd4, 32'hC0FF_EE11, {27'h5A5A5A5, 5'(k)}, 5'd0);

    // R6 / R7: signed-count boundaries
    for (int k = 0; k < 12; k++) begin
      run_op(3'd5, 32'h8765_4321, sha_counts[k], 5'd0);
      run_op(3'd5, 32'h1234_5679, sha_counts[k], 5'd0);
    end

    // R9: reserved codes; R8: zero result
    run_op(3'd6, 32'hDEAD_BEEF, 32'h0, 5'd3);
    run_op(3'd7, 32'h0, 32'h0, 5'd0);
    run_op(3'd1, 32'h0000_0001, 32'h0, 5'd1);

    // Random mix over all operations
    for (int k = 0; k < 1600; k++) begin
      logic [2:0]  rop;
      logic [31:0] rc;
      rop = 3'($urandom_range(0, 7));
      rc  = $urandom();
      if ($urandom_range(0, 1) == 0) rc = 32'($signed(6'($urandom_range(0, 63)) - 6'sd0) - 32);
      run_op(rop, $urandom(), rc, 5'($urandom_range(0, 31)));
    end

    // R10: outputs hold while in_valid is low
    run_op(3'd2, 32'hF000_000F, 32'h0, 5'd4);
    keep_r = result; keep_z = flag_z; keep_n = flag_n; keep_c = flag_c;
    operand = 32'h0; op_sel = 3'd1; imm = 5'd0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== keep_r || flag_z !== keep_z ||
        flag_n !== keep_n || flag_c !== keep_c) begin
      errors++;
      $display("FAIL R10 hold: got v=%b r=%h c=%b exp v=0 r=%h c=%b",
               out_valid, result, flag_c, keep_r, keep_c);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule